// File: doc/BRIEF.md
# Write-Update Write-Back Snooping Coherence Controller

This block keeps several small private caches coherent over one shared byte-wide memory. Each processor port issues a read or a write of one byte. A single transaction is carried out per bus grant. During that transaction every cache is snooped on the requested address. A peer that holds the byte supplies it, and the backing memory supplies it only when no peer holds it. A write to a shared byte does not invalidate the other copies. Instead the new value is pushed into every cache that holds the byte.

Each cache entry is in one of four live states. Two of them are exclusive: a clean sole copy and a modified sole copy. Two of them are shared: a plain sharer and an owning sharer. The owning sharer is the cache that wrote last, and it carries the write-back duty for the byte. When an owner is evicted, its byte is written back to memory. When a clean copy is evicted, it is dropped without a write-back. The caller supplies the victim way for a miss. The block uses that way only when the cache has no free way.

Requests are held until answered. A one-cycle response on the requester's strobe returns the requester's byte, its new state, the hit flag and whether a victim was written back.

Top module: `coh_update_ctrl`

## Requirements
- R1: Entry states are encoded on `resp_state` as 0 invalid, 1 exclusive-clean, 2 shared-clean, 3 shared-owner, 4 exclusive-modified. The requester receives a single one-cycle `resp_valid` strobe one cycle after its grant. No other port receives a strobe. After reset no strobe is raised.
- R2: A read miss that no peer holds takes the byte from memory and installs it as exclusive-clean (1).
- R3: A read miss that a peer supplies while holding state 3 or 4 leaves the supplier in state 3 and the requester in state 2.
- R4: A read miss that a peer supplies while holding state 1 or 2 leaves both the supplier and the requester in state 2.
- R5: A write hit on state 1 or 4 writes the byte locally and ends in state 4.
- R6: A write hit on state 2 or 3 writes the byte into every holder. The writer ends in state 3 and every other holder ends in state 2.
- R7: A write miss that a peer holds takes the byte from a peer, writes it and pushes it to all holders. The writer ends in state 3 and every holder ends in state 2.
- R8: A write miss that no peer holds installs the written byte in state 4.
- R9: Evicting an entry in state 3 or 4 writes its byte back to memory and raises `resp_wb`. Evicting an entry in state 1 or 2 does neither. A hit never raises `resp_wb`.
- R10: On a miss, the lowest-numbered free way is filled. The `req_victim` way of the requester is used only when every way is live.
- R11: Among pending requests, the grant goes to the first requester found counting upward from the port after the one granted last, wrapping from the last port to port 0. Port 0 is searched first after reset. No grant is issued in the response cycle.
- R12: A read hit returns the stored byte with `resp_hit` high and leaves the states of all copies unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_CACHE | Per-port request, held until answered |
| req_write | input | N_CACHE | Per-port operation: 1 write, 0 read |
| req_addr | input | N_CACHE*AW | Per-port byte address, port p at bits p*AW |
| req_wdata | input | N_CACHE*DW | Per-port write byte, port p at bits p*DW |
| req_victim | input | N_CACHE*WW | Per-port way chosen by the replacement selector |
| resp_valid | output | N_CACHE | One-cycle strobe to the answered port |
| resp_rdata | output | DW | Requester's byte after the transaction |
| resp_state | output | 3 | Requester's entry state after the transaction |
| resp_hit | output | 1 | The requester already held the byte |
| resp_wb | output | 1 | A modified victim was written back |

## Verification
Two functions can fall in the same transaction. A modified victim can be written back to memory while a write miss is answered by a peer and pushed to every holder. The bench provokes this by letting a port that owns one address write a second address that two peers share, with the owned entry named as victim. The response must show the new byte, the owning state and `resp_wb` high, and both peers must later read back the new byte as sharers. A following cold read of the evicted address must return the written-back byte. Simultaneous requests from two ports are also driven on one edge. The order of service is judged from the data and states the later requester sees.

// File: rtl/coh_pkg.sv
package coh_pkg;

   // Entry state, numeric values are visible on resp_state.
   typedef enum logic [2:0] {
      ST_INV = 3'd0,
      ST_VX  = 3'd1,
      ST_SC  = 3'd2,
      ST_SD  = 3'd3,
      ST_DT  = 3'd4
   } coh_state_e;

   // The entry carries the write-back duty.
   function automatic logic is_owner(coh_state_e s);
      return (s == ST_SD) || (s == ST_DT);
   endfunction

   // The entry may have copies in other caches.
   function automatic logic is_shared(coh_state_e s);
      return (s == ST_SC) || (s == ST_SD);
   endfunction

endpackage

// File: rtl/coh_arbiter.sv
module coh_arbiter #(
   parameter int N           = 3,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   localparam int PW = (N > 1) ? $clog2(N) : 1;

   generate
      if (ROUND_ROBIN) begin : g_rr
         logic [PW-1:0] ptr;
         logic          found;

         // Search ports at or above the pointer first, then wrap to the rest.
         always_comb begin
            grant = '0;
            found = 1'b0;
            for (int j = 0; j < N; j++) begin
               if (en && !found && req[j] && (PW'(j) >= ptr)) begin
                  grant[j] = 1'b1;
                  found    = 1'b1;
               end
            end
            for (int j = 0; j < N; j++) begin
               if (en && !found && req[j] && (PW'(j) < ptr)) begin
                  grant[j] = 1'b1;
                  found    = 1'b1;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ptr <= '0;
            end else begin
               for (int j = 0; j < N; j++) begin
                  if (grant[j]) ptr <= (j == N - 1) ? '0 : PW'(j + 1);
               end
            end
         end
      end else begin : g_fixed
         logic found;

         always_comb begin
            grant = '0;
            found = 1'b0;
            for (int j = 0; j < N; j++) begin
               if (en && !found && req[j]) begin
                  grant[j] = 1'b1;
                  found    = 1'b1;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/coh_way_lookup.sv
module coh_way_lookup #(
   parameter int WAYS = 2,
   parameter int AW   = 4,
   parameter int WW   = 1
) (
   input  logic [WAYS-1:0]         live,
   input  logic [WAYS-1:0][AW-1:0] tags,
   input  logic [AW-1:0]           addr,
   output logic                    hit,
   output logic [WW-1:0]           hit_way,
   output logic                    has_free,
   output logic [WW-1:0]           free_way
);
   // Lowest matching live way and lowest empty way.
   always_comb begin
      hit      = 1'b0;
      hit_way  = '0;
      has_free = 1'b0;
      free_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (!hit && live[w] && (tags[w] == addr)) begin
            hit     = 1'b1;
            hit_way = WW'(w);
         end
         if (!has_free && !live[w]) begin
            has_free = 1'b1;
            free_way = WW'(w);
         end
      end
   end

endmodule

// File: rtl/coh_update_ctrl.sv
module coh_update_ctrl
   import coh_pkg::*;
#(
   parameter int   N_CACHE     = 3,
   parameter int   WAYS        = 2,
   parameter int   AW          = 4,
   parameter int   DW          = 8,
   parameter bit   ROUND_ROBIN = 1'b1,
   localparam int  WW          = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_CACHE-1:0]    req_valid,
   input  logic [N_CACHE-1:0]    req_write,
   input  logic [N_CACHE*AW-1:0] req_addr,
   input  logic [N_CACHE*DW-1:0] req_wdata,
   input  logic [N_CACHE*WW-1:0] req_victim,
   output logic [N_CACHE-1:0]    resp_valid,
   output logic [DW-1:0]         resp_rdata,
   output logic [2:0]            resp_state,
   output logic                  resp_hit,
   output logic                  resp_wb
);
   localparam int NW    = (N_CACHE > 1) ? $clog2(N_CACHE) : 1;
   localparam int DEPTH = 1 << AW;

   generate
      if (N_CACHE < 2) begin : g_chk_n
         $error("coh_update_ctrl: N_CACHE must be at least 2");
      end
      if (WAYS < 1) begin : g_chk_ways
         $error("coh_update_ctrl: WAYS must be at least 1");
      end
      if (AW < 1 || AW > 12) begin : g_chk_aw
         $error("coh_update_ctrl: AW must lie in 1..12");
      end
   endgenerate

   // ---------------- storage ----------------
   coh_state_e                          st_q [N_CACHE][WAYS];
   logic [N_CACHE-1:0][WAYS-1:0][AW-1:0] tag_q;
   logic [N_CACHE-1:0][WAYS-1:0][DW-1:0] dat_q;
   logic [DW-1:0]                       mem_q [DEPTH];
   logic                                busy;

   // ---------------- arbitration ----------------
   logic [N_CACHE-1:0] grant_oh;
   logic               go;

   coh_arbiter #(.N(N_CACHE), .ROUND_ROBIN(ROUND_ROBIN)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (!busy),
      .req   (req_valid),
      .grant (grant_oh)
   );

   assign go = |grant_oh;

   // Granted request fields.
   logic [NW-1:0] g_idx;
   logic          g_write;
   logic [AW-1:0] g_addr;
   logic [DW-1:0] g_wdata;
   logic [WW-1:0] g_victim;

   always_comb begin
      g_idx    = '0;
      g_write  = 1'b0;
      g_addr   = '0;
      g_wdata  = '0;
      g_victim = '0;
      for (int c = 0; c < N_CACHE; c++) begin
         if (grant_oh[c]) begin
            g_idx    = NW'(c);
            g_write  = req_write[c];
            g_addr   = req_addr[c*AW +: AW];
            g_wdata  = req_wdata[c*DW +: DW];
            g_victim = req_victim[c*WW +: WW];
         end
      end
   end

   // ---------------- snoop of every cache ----------------
   logic [N_CACHE-1:0][WAYS-1:0] live;
   logic [N_CACHE-1:0]           c_hit;
   logic [N_CACHE-1:0][WW-1:0]   c_way;
   logic [N_CACHE-1:0]           c_free;
   logic [N_CACHE-1:0][WW-1:0]   c_fway;

   always_comb begin
      for (int c = 0; c < N_CACHE; c++) begin
         for (int w = 0; w < WAYS; w++) begin
            live[c][w] = (st_q[c][w] != ST_INV);
         end
      end
   end

   generate
      for (genvar c = 0; c < N_CACHE; c++) begin : g_snoop
         coh_way_lookup #(.WAYS(WAYS), .AW(AW), .WW(WW)) u_look (
            .live     (live[c]),
            .tags     (tag_q[c]),
            .addr     (g_addr),
            .hit      (c_hit[c]),
            .hit_way  (c_way[c]),
            .has_free (c_free[c]),
            .free_way (c_fway[c])
         );
      end
   endgenerate

   // Peers that hold the byte, and those among them that own it.
   logic [N_CACHE-1:0] holder;
   logic [N_CACHE-1:0] owner;

   always_comb begin
      for (int c = 0; c < N_CACHE; c++) begin
         holder[c] = c_hit[c] && (NW'(c) != g_idx);
         owner[c]  = holder[c] && is_owner(st_q[c][c_way[c]]);
      end
   end

   // Supplier: an owner if one exists, else the lowest-numbered holder.
   logic          sup_any;
   logic          sup_is_owner;
   logic [NW-1:0] sup_idx;

   always_comb begin
      sup_any      = 1'b0;
      sup_is_owner = 1'b0;
      sup_idx      = '0;
      for (int c = 0; c < N_CACHE; c++) begin
         if (!sup_any && owner[c]) begin
            sup_any      = 1'b1;
            sup_is_owner = 1'b1;
            sup_idx      = NW'(c);
         end
      end
      for (int c = 0; c < N_CACHE; c++) begin
         if (!sup_any && holder[c]) begin
            sup_any = 1'b1;
            sup_idx = NW'(c);
         end
      end
   end

   // ---------------- requester decision ----------------
   logic          own_hit;
   logic [WW-1:0] own_way;
   coh_state_e    own_old;
   logic [AW-1:0] own_old_tag;
   logic [DW-1:0] own_old_data;
   logic [DW-1:0] sup_data;
   logic          wb;
   logic          broadcast;
   coh_state_e    new_state;
   logic [DW-1:0] new_data;
   coh_state_e    sup_next;

   always_comb begin
      own_hit      = c_hit[g_idx];
      own_way      = own_hit ? c_way[g_idx]
                   : (c_free[g_idx] ? c_fway[g_idx] : g_victim);
      own_old      = st_q[g_idx][own_way];
      own_old_tag  = tag_q[g_idx][own_way];
      own_old_data = dat_q[g_idx][own_way];
      sup_data     = dat_q[sup_idx][c_way[sup_idx]];
      wb           = go && !own_hit && is_owner(own_old);
      broadcast    = g_write && ((|holder) || (own_hit && is_shared(own_old)));
      sup_next     = sup_is_owner ? ST_SD : ST_SC;

      if (own_hit && !g_write) begin
         new_state = own_old;
         new_data  = own_old_data;
      end else if (g_write) begin
         new_state = broadcast ? ST_SD : ST_DT;
         new_data  = g_wdata;
      end else begin
         new_state = sup_any ? ST_SC : ST_VX;
         new_data  = sup_any ? sup_data : mem_q[g_addr];
      end
   end

   // ---------------- state, memory and response ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         resp_valid <= '0;
         resp_rdata <= '0;
         resp_state <= '0;
         resp_hit   <= 1'b0;
         resp_wb    <= 1'b0;
         for (int c = 0; c < N_CACHE; c++) begin
            for (int w = 0; w < WAYS; w++) begin
               st_q[c][w] <= ST_INV;
            end
         end
         for (int a = 0; a < DEPTH; a++) begin
            mem_q[a] <= '0;
         end
      end else begin
         busy       <= go;
         resp_valid <= grant_oh;
         if (go) begin
            resp_rdata <= new_data;
            resp_state <= new_state;
            resp_hit   <= own_hit;
            resp_wb    <= wb;
            if (wb) mem_q[own_old_tag] <= own_old_data;
            for (int c = 0; c < N_CACHE; c++) begin
               for (int w = 0; w < WAYS; w++) begin
                  if ((NW'(c) == g_idx) && (WW'(w) == own_way)) begin
                     st_q[c][w] <= new_state;
                  end else if (holder[c] && (WW'(w) == c_way[c])) begin
                     if (broadcast) begin
                        st_q[c][w] <= ST_SC;
                     end else if (!g_write && !own_hit && (NW'(c) == sup_idx)) begin
                        st_q[c][w] <= sup_next;
                     end
                  end
               end
            end
         end
      end
   end

   // Tags and bytes need no reset: a state of invalid masks them.
   always_ff @(posedge clk) begin
      if (go) begin
         for (int c = 0; c < N_CACHE; c++) begin
            for (int w = 0; w < WAYS; w++) begin
               if ((NW'(c) == g_idx) && (WW'(w) == own_way)) begin
                  tag_q[c][w] <= g_addr;
                  dat_q[c][w] <= new_data;
               end else if (holder[c] && broadcast && (WW'(w) == c_way[c])) begin
                  dat_q[c][w] <= g_wdata;
               end
            end
         end
      end
   end

endmodule

// File: rtl/coh_update_ctrl_chk.sv
module coh_update_ctrl_chk #(
   parameter int N_CACHE = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_CACHE-1:0] req_valid,
   input logic [N_CACHE-1:0] grant_oh,
   input logic               busy,
   input logic [N_CACHE-1:0] resp_valid,
   input logic [2:0]         resp_state,
   input logic               resp_hit,
   input logic               resp_wb
);
   // R1: at most one port is answered at a time
   p_resp_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(resp_valid));

   // R1: a response strobe lasts one cycle
   p_resp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid != '0) |=> (resp_valid == '0));

   // R1: the granted port is answered in the next cycle
   p_grant_answered_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_oh != '0) |=> (resp_valid == $past(grant_oh)));

   // R1: a reported state is one of the four live encodings
   p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid != '0) |-> (resp_state >= 3'd1 && resp_state <= 3'd4));

   // R9: a hit never evicts
   p_hit_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((resp_valid != '0) && resp_hit) |-> !resp_wb);

   // R11: grants are one-hot and only to requesting ports
   p_grant_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_oh) && ((grant_oh & ~req_valid) == '0));

   // R11: no grant while a response is out
   p_no_grant_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (grant_oh == '0));

endmodule

bind coh_update_ctrl coh_update_ctrl_chk #(.N_CACHE(N_CACHE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .grant_oh   (grant_oh),
   .busy       (busy),
   .resp_valid (resp_valid),
   .resp_state (resp_state),
   .resp_hit   (resp_hit),
   .resp_wb    (resp_wb)
);

// File: tb/coh_update_ctrl_test.sv
`timescale 1ns/1ps
module coh_update_ctrl_test;
   localparam int N  = 3;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int WW = 1;
   localparam logic [2:0] S_VX = 3'd1, S_SC = 3'd2, S_SD = 3'd3, S_DT = 3'd4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req_valid = '0;
   logic [N-1:0]    req_write = '0;
   logic [N*AW-1:0] req_addr = '0;
   logic [N*DW-1:0] req_wdata = '0;
   logic [N*WW-1:0] req_victim = '0;
   logic [N-1:0]    resp_valid;
   logic [DW-1:0]   resp_rdata;
   logic [2:0]      resp_state;
   logic            resp_hit;
   logic            resp_wb;

   coh_update_ctrl #(.N_CACHE(N), .WAYS(2), .AW(AW), .DW(DW), .ROUND_ROBIN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_victim(req_victim),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata), .resp_state(resp_state),
      .resp_hit(resp_hit), .resp_wb(resp_wb)
   );

   always #2 clk = ~clk;

   typedef struct {
      logic [DW-1:0] d;
      logic [2:0]    s;
      logic          h;
      logic          wb;
      string         tag;
   } exp_t;

   exp_t q0[$];
   exp_t q1[$];
   exp_t q2[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   ended = 1'b0;

   task automatic push_exp(input int p, input exp_t e);
      case (p)
         0: q0.push_back(e);
         1: q1.push_back(e);
         default: q2.push_back(e);
      endcase
   endtask

   // Driver: queue the expected answer, raise the request, hold it until answered.
   task automatic txn(input int p, input bit wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input bit vic,
                      input logic [DW-1:0] ed, input logic [2:0] es,
                      input bit eh, input bit ewb, input string tag);
      exp_t e;
      e.d = ed; e.s = es; e.h = eh; e.wb = ewb; e.tag = tag;
      push_exp(p, e);
      @(negedge clk);
      req_write[p]            = wr;
      req_addr[p*AW +: AW]    = a;
      req_wdata[p*DW +: DW]   = d;
      req_victim[p*WW +: WW]  = vic;
      req_valid[p]            = 1'b1;
      do @(negedge clk); while (!resp_valid[p]);
      req_valid[p] = 1'b0;
   endtask

   // Monitor: pop and compare on each strobe, away from the clock edge.
   always @(negedge clk) begin
      if (rst_n) begin
         for (int p = 0; p < N; p++) begin
            if (resp_valid[p]) begin
               exp_t e;
               bit   have;
               have = 1'b1;
               case (p)
                  0: if (q0.size() == 0) have = 1'b0; else e = q0.pop_front();
                  1: if (q1.size() == 0) have = 1'b0; else e = q1.pop_front();
                  default: if (q2.size() == 0) have = 1'b0; else e = q2.pop_front();
               endcase
               n_chk++;
               if (!have) begin
                  n_fail++;
                  $display("FAIL R1 port %0d: unexpected strobe, actual 1 expected 0", p);
               end else if (resp_rdata !== e.d || resp_state !== e.s ||
                            resp_hit !== e.h || resp_wb !== e.wb) begin
                  n_fail++;
                  $display("FAIL %s port %0d: actual d=%h s=%0d h=%0b wb=%0b expected d=%h s=%0d h=%0b wb=%0b",
                           e.tag, p, resp_rdata, resp_state, resp_hit, resp_wb,
                           e.d, e.s, e.h, e.wb);
               end
            end
         end
      end
   end

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (resp_valid !== '0) begin
         n_fail++;
         $display("FAIL R1 reset: actual resp_valid=%b expected 000", resp_valid);
      end

      txn(0, 1, 4'd3, 8'h11, 0, 8'h11, S_DT, 0, 0, "R8 write miss cold");
      txn(1, 0, 4'd3, 8'h00, 0, 8'h11, S_SC, 0, 0, "R3 read from modified peer");
      txn(0, 0, 4'd3, 8'h00, 0, 8'h11, S_SD, 1, 0, "R3 supplier turned owner");
      txn(1, 1, 4'd3, 8'h22, 0, 8'h22, S_SD, 1, 0, "R6 write hit shared");
      txn(0, 0, 4'd3, 8'h00, 0, 8'h22, S_SC, 1, 0, "R6 sharer updated");
      txn(2, 0, 4'd3, 8'h00, 0, 8'h22, S_SC, 0, 0, "R3 owner supplies");
      txn(1, 0, 4'd3, 8'h00, 0, 8'h22, S_SD, 1, 0, "R12 read hit keeps owner");
      txn(2, 1, 4'd4, 8'h33, 0, 8'h33, S_DT, 0, 0, "R8 R10 free way");
      txn(1, 0, 4'd4, 8'h00, 0, 8'h33, S_SC, 0, 0, "R3 read second byte");
      txn(2, 0, 4'd4, 8'h00, 0, 8'h33, S_SD, 1, 0, "R3 owner state");
      txn(1, 1, 4'd4, 8'h55, 0, 8'h55, S_SD, 1, 0, "R6 sharer writes");
      txn(2, 0, 4'd8, 8'h00, 1, 8'h00, S_VX, 0, 0, "R2 R9 clean victim");
      txn(1, 0, 4'd8, 8'h00, 1, 8'h00, S_SC, 0, 1, "R4 R9 owner victim");
      txn(2, 0, 4'd8, 8'h00, 0, 8'h00, S_SC, 1, 0, "R4 clean supplier shared");
      txn(0, 0, 4'd4, 8'h00, 0, 8'h55, S_VX, 0, 0, "R9 R2 written-back byte");
      txn(0, 1, 4'd4, 8'h66, 0, 8'h66, S_DT, 1, 0, "R5 write hit clean");
      txn(0, 1, 4'd4, 8'h77, 0, 8'h77, S_DT, 1, 0, "R5 write hit modified");
      txn(2, 1, 4'd4, 8'h88, 0, 8'h88, S_SD, 0, 0, "R7 R10 write miss peer");
      txn(0, 0, 4'd4, 8'h00, 0, 8'h88, S_SC, 1, 0, "R7 supplier shared");
      txn(1, 1, 4'd4, 8'h99, 0, 8'h99, S_SD, 0, 1, "R7 R9 write-back with push");
      txn(2, 0, 4'd4, 8'h00, 0, 8'h99, S_SC, 1, 0, "R7 old owner shared");
      txn(0, 0, 4'd4, 8'h00, 0, 8'h99, S_SC, 1, 0, "R7 sharer pushed");
      txn(0, 0, 4'd9, 8'h00, 0, 8'h00, S_VX, 0, 0, "R10 victim way used");
      txn(2, 0, 4'd3, 8'h00, 1, 8'h22, S_VX, 0, 0, "R9 written-back value");

      // R11: last grant was port 2, so port 0 is searched first.
      fork
         txn(0, 1, 4'd10, 8'hA1, 0, 8'hA1, S_DT, 0, 0, "R11 port 0 first");
         txn(1, 1, 4'd10, 8'hB2, 1, 8'hB2, S_SD, 0, 0, "R11 port 1 second");
      join
      // R11: last grant was port 1, so port 2 beats port 0.
      fork
         txn(0, 0, 4'd10, 8'h00, 0, 8'hC3, S_SC, 1, 0, "R11 port 0 after port 2");
         txn(2, 1, 4'd10, 8'hC3, 1, 8'hC3, S_SD, 0, 0, "R11 port 2 first");
      join

      repeat (4) @(negedge clk);
      n_chk++;
      if (q0.size() + q1.size() + q2.size() != 0) begin
         n_fail++;
         $display("FAIL R1 missing answers: actual %0d pending expected 0",
                  q0.size() + q1.size() + q2.size());
      end
      finish_run();
   end

endmodule